// File: doc/BRIEF.md
# Special-Register Access Unit

This block serves the move-to and move-from special-register operations of a small 32-bit core. The core presents a 16-bit register address, write data, a write or read strobe, its supervisor-mode bit and the value the destination register held before the operation. Each address is built as a 5-bit group number shifted left by 11 bits plus an 11-bit index inside that group. The unit keeps the exception-related registers, the exception vector base, a 64-bit multiply-accumulate value split into two 32-bit halves, a power-management register and a banked file of shadow general registers. It also answers a set of read-only identification values fixed at build time.

Only the floating-point control/status register may be touched from user mode. Any other access from user mode traps with an illegal-instruction pulse and leaves all state alone. Addresses the unit does not implement, including the ranges of the upper translation-buffer ways, are accepted quietly in supervisor mode: writes vanish and reads hand back the old destination value, so the core's register file keeps its contents. Read data is combinational from the address. Writes land on the rising clock edge. A write to the power-management register that sets a doze or sleep bit produces a one-cycle halt request, together with the address the core resumes at.

Top module: `sreg_access`

## Requirements
- R1: After reset, `illegal` and `halt` are low, and a supervisor read of the floating-point status, vector base, exception PC, exception address, exception status, both accumulator halves and the power register returns 0.
- R2: Address 0x0014 (group 0, index 20) is readable and writable in both user and supervisor mode and never raises `illegal`.
- R3: With `sup_mode` low, a strobe on any address other than 0x0014 raises `illegal` for one cycle after the strobed edge. It changes no register, and `rdata` equals `rd_prev` during that access.
- R4: In supervisor mode the vector base (0x000B), exception PC (0x0020), exception address (0x0030) and exception status (0x0040) hold 32-bit values written to them. A written value is returned by reads from the cycle after the write edge.
- R5: Shadow registers occupy 0x0400 upward. An offset `o` from 0x0400 selects bank `o/32`, register `o%32`, for `SH_BANKS` banks. Every entry is independent, and an offset past the last bank is unmapped.
- R6: The accumulator low word is at 0x2801 (group 5, index 1) and the high word at 0x2802 (group 5, index 2). Writing one half leaves the other unchanged.
- R7: A supervisor write to 0x4000 (group 8, index 0) stores the value. If data bit 4 (doze) or bit 5 (sleep) is set, `halt` is high for exactly the one cycle after the write edge, and `resume_pc` then equals `pc_in` + 4. A write with both bits clear gives no halt.
- R8: In groups 1 and 2, indexes 768 to 1535 raise no exception in supervisor mode, drop writes and return `rd_prev` on reads.
- R9: A supervisor read of any other unimplemented address returns `rd_prev` and raises no exception.
- R10: Addresses 0x0000, 0x0001, 0x0002, 0x0080 and 0x0081 return the parameters `VERSION_VAL`, `UNITS_VAL`, `CFG_VAL`, `CORE_ID` and `CORE_COUNT`, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | 16 | Register address, group in [15:11], index in [10:0] |
| wdata | input | DW | Write data |
| wr_en | input | 1 | Write strobe |
| rd_en | input | 1 | Read strobe |
| sup_mode | input | 1 | Core is in supervisor mode |
| rd_prev | input | DW | Previous destination-register value |
| pc_in | input | PC_W | Address of the current instruction |
| rdata | output | DW | Read data, combinational from the address |
| illegal | output | 1 | Illegal-instruction pulse |
| halt | output | 1 | Halt request pulse |
| resume_pc | output | PC_W | Address to resume at after a halt |

## Verification
`rdata` depends only on the present address, mode, `rd_prev` and stored state. The bench therefore drives each access on the falling edge and samples `rdata` 1 ns later, in the same cycle. `illegal`, `halt` and `resume_pc` come from registers loaded on the edge that takes the strobe, so they are sampled 1 ns after that rising edge. A write becomes visible to reads from the next access onward. An idle cycle after each halt confirms that the pulse has dropped.

// File: rtl/sreg_pkg.sv
package sreg_pkg;

  localparam int ADDR_W      = 16;
  localparam int GRP_SHIFT   = 11;
  localparam int SHADOW_BASE = 1024;
  localparam int TLBX_LO     = 768;
  localparam int TLBX_HI     = 1535;
  localparam int DOZE_BIT    = 4;
  localparam int SLEEP_BIT   = 5;

  function automatic logic [ADDR_W-1:0] sreg_addr(input int unsigned grp, input int unsigned idx);
    return ADDR_W'((grp << GRP_SHIFT) + idx);
  endfunction

  localparam logic [ADDR_W-1:0] A_VERSION = sreg_addr(0, 0);
  localparam logic [ADDR_W-1:0] A_UNITS   = sreg_addr(0, 1);
  localparam logic [ADDR_W-1:0] A_CFG     = sreg_addr(0, 2);
  localparam logic [ADDR_W-1:0] A_VBASE   = sreg_addr(0, 11);
  localparam logic [ADDR_W-1:0] A_FPSTAT  = sreg_addr(0, 20);
  localparam logic [ADDR_W-1:0] A_EPC     = sreg_addr(0, 32);
  localparam logic [ADDR_W-1:0] A_EADDR   = sreg_addr(0, 48);
  localparam logic [ADDR_W-1:0] A_ESTAT   = sreg_addr(0, 64);
  localparam logic [ADDR_W-1:0] A_COREID  = sreg_addr(0, 128);
  localparam logic [ADDR_W-1:0] A_NCORES  = sreg_addr(0, 129);
  localparam logic [ADDR_W-1:0] A_ACC_LO  = sreg_addr(5, 1);
  localparam logic [ADDR_W-1:0] A_ACC_HI  = sreg_addr(5, 2);
  localparam logic [ADDR_W-1:0] A_PWR     = sreg_addr(8, 0);

  typedef enum logic [3:0] {
    SEL_NONE, SEL_FPSTAT, SEL_VBASE, SEL_EPC, SEL_EADDR, SEL_ESTAT,
    SEL_ACC_LO, SEL_ACC_HI, SEL_PWR, SEL_SHADOW, SEL_VERSION,
    SEL_UNITS, SEL_CFG, SEL_COREID, SEL_NCORES, SEL_TLBX
  } sel_e;

endpackage

// File: rtl/sreg_decode.sv
module sreg_decode
  import sreg_pkg::*;
#(
  parameter int SH_DEPTH     = 128,
  parameter int SH_BANK_REGS = 32,
  parameter int SH_AW        = $clog2(SH_DEPTH)
) (
  input  logic [ADDR_W-1:0] addr,
  output sel_e              sel,
  output logic [SH_AW-1:0]  sh_idx
);

  logic [4:0]  grp;
  logic [10:0] idx;
  int          off;
  int          bank;
  int          slot;

  assign grp = addr[15:11];
  assign idx = addr[10:0];

  always_comb begin
    sel    = SEL_NONE;
    sh_idx = '0;
    off    = int'(idx) - SHADOW_BASE;
    bank   = 0;
    slot   = 0;
    case (addr)
      A_FPSTAT:  sel = SEL_FPSTAT;
      A_VBASE:   sel = SEL_VBASE;
      A_EPC:     sel = SEL_EPC;
      A_EADDR:   sel = SEL_EADDR;
      A_ESTAT:   sel = SEL_ESTAT;
      A_ACC_LO:  sel = SEL_ACC_LO;
      A_ACC_HI:  sel = SEL_ACC_HI;
      A_PWR:     sel = SEL_PWR;
      A_VERSION: sel = SEL_VERSION;
      A_UNITS:   sel = SEL_UNITS;
      A_CFG:     sel = SEL_CFG;
      A_COREID:  sel = SEL_COREID;
      A_NCORES:  sel = SEL_NCORES;
      default: begin
        if (grp == 5'd0 && off >= 0 && off < SH_DEPTH) begin
          sel  = SEL_SHADOW;
          bank = off / SH_BANK_REGS;
          slot = off % SH_BANK_REGS;
          sh_idx = SH_AW'(bank * SH_BANK_REGS + slot);
        end else if ((grp == 5'd1 || grp == 5'd2) &&
                     int'(idx) >= TLBX_LO && int'(idx) <= TLBX_HI) begin
          sel = SEL_TLBX;
        end
      end
    endcase
  end

endmodule

// File: rtl/sreg_shadow.sv
module sreg_shadow #(
  parameter int DEPTH = 128,
  parameter int AW    = $clog2(DEPTH),
  parameter int DW    = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] idx,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[idx] <= wdata;
  end

  assign rdata = mem[idx];

endmodule

// File: rtl/sreg_state.sv
module sreg_state
  import sreg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  sel_e          sel,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] fpstat,
  output logic [DW-1:0] vbase,
  output logic [DW-1:0] epc,
  output logic [DW-1:0] eaddr,
  output logic [DW-1:0] estat,
  output logic [2*DW-1:0] acc,
  output logic [DW-1:0] pwr
);

  always_ff @(posedge clk) begin
    if (rst) begin
      fpstat <= '0;
      vbase  <= '0;
      epc    <= '0;
      eaddr  <= '0;
      estat  <= '0;
      acc    <= '0;
      pwr    <= '0;
    end else if (we) begin
      case (sel)
        SEL_FPSTAT: fpstat <= wdata;
        SEL_VBASE:  vbase  <= wdata;
        SEL_EPC:    epc    <= wdata;
        SEL_EADDR:  eaddr  <= wdata;
        SEL_ESTAT:  estat  <= wdata;
        SEL_ACC_LO: acc[DW-1:0]    <= wdata;
        SEL_ACC_HI: acc[2*DW-1:DW] <= wdata;
        SEL_PWR:    pwr    <= wdata;
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sreg_access.sv
module sreg_access
  import sreg_pkg::*;
#(
  parameter int          DW           = 32,
  parameter int          PC_W         = 32,
  parameter int          SH_BANKS     = 4,
  parameter int          SH_BANK_REGS = 32,
  parameter logic [31:0] VERSION_VAL  = 32'h1300_0007,
  parameter logic [31:0] UNITS_VAL    = 32'h0000_0431,
  parameter logic [31:0] CFG_VAL      = 32'h0000_0220,
  parameter logic [31:0] CORE_ID      = 32'h0000_0000,
  parameter logic [31:0] CORE_COUNT   = 32'h0000_0001
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [15:0]     addr,
  input  logic [DW-1:0]   wdata,
  input  logic            wr_en,
  input  logic            rd_en,
  input  logic            sup_mode,
  input  logic [DW-1:0]   rd_prev,
  input  logic [PC_W-1:0] pc_in,
  output logic [DW-1:0]   rdata,
  output logic            illegal,
  output logic            halt,
  output logic [PC_W-1:0] resume_pc
);

  localparam int SH_DEPTH = SH_BANKS * SH_BANK_REGS;
  localparam int SH_AW    = (SH_DEPTH > 1) ? $clog2(SH_DEPTH) : 1;

  sel_e             sel;
  logic [SH_AW-1:0] sh_idx;
  logic             blocked;
  logic             wr_ok;
  logic             sleep_req;
  logic [DW-1:0]    fpstat, vbase, epc, eaddr, estat, pwr, sh_rdata;
  logic [2*DW-1:0]  acc;

  sreg_decode #(
    .SH_DEPTH(SH_DEPTH), .SH_BANK_REGS(SH_BANK_REGS), .SH_AW(SH_AW)
  ) u_decode (
    .addr(addr), .sel(sel), .sh_idx(sh_idx)
  );

  // user mode may only touch the floating-point status register
  assign blocked   = !sup_mode && (sel != SEL_FPSTAT);
  assign wr_ok     = wr_en && !blocked;
  assign sleep_req = wr_ok && (sel == SEL_PWR) && (wdata[DOZE_BIT] || wdata[SLEEP_BIT]);

  sreg_state #(.DW(DW)) u_state (
    .clk(clk), .rst(rst), .we(wr_ok), .sel(sel), .wdata(wdata),
    .fpstat(fpstat), .vbase(vbase), .epc(epc), .eaddr(eaddr),
    .estat(estat), .acc(acc), .pwr(pwr)
  );

  sreg_shadow #(.DEPTH(SH_DEPTH), .AW(SH_AW), .DW(DW)) u_shadow (
    .clk(clk), .we(wr_ok && sel == SEL_SHADOW), .idx(sh_idx),
    .wdata(wdata), .rdata(sh_rdata)
  );

  always_comb begin
    rdata = rd_prev;
    if (!blocked) begin
      case (sel)
        SEL_FPSTAT:  rdata = fpstat;
        SEL_VBASE:   rdata = vbase;
        SEL_EPC:     rdata = epc;
        SEL_EADDR:   rdata = eaddr;
        SEL_ESTAT:   rdata = estat;
        SEL_ACC_LO:  rdata = acc[DW-1:0];
        SEL_ACC_HI:  rdata = acc[2*DW-1:DW];
        SEL_PWR:     rdata = pwr;
        SEL_SHADOW:  rdata = sh_rdata;
        SEL_VERSION: rdata = DW'(VERSION_VAL);
        SEL_UNITS:   rdata = DW'(UNITS_VAL);
        SEL_CFG:     rdata = DW'(CFG_VAL);
        SEL_COREID:  rdata = DW'(CORE_ID);
        SEL_NCORES:  rdata = DW'(CORE_COUNT);
        default:     rdata = rd_prev;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      illegal   <= 1'b0;
      halt      <= 1'b0;
      resume_pc <= '0;
    end else begin
      illegal <= (wr_en || rd_en) && blocked;
      halt    <= sleep_req;
      if (sleep_req) resume_pc <= pc_in + PC_W'(4);
    end
  end

endmodule

// File: rtl/sreg_access_chk.sv
module sreg_access_chk #(
  parameter int DW   = 32,
  parameter int PC_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic [15:0]     addr,
  input logic            wr_en,
  input logic            rd_en,
  input logic            sup_mode,
  input logic [DW-1:0]   rd_prev,
  input logic [DW-1:0]   rdata,
  input logic [PC_W-1:0] pc_in,
  input logic            illegal,
  input logic            halt,
  input logic [PC_W-1:0] resume_pc
);

  AST_USER_TRAP: assert property (@(posedge clk) disable iff (rst)
    ((wr_en || rd_en) && !sup_mode && addr != 16'h0014) |=> illegal); // R3

  AST_SUPER_NO_TRAP: assert property (@(posedge clk) disable iff (rst)
    sup_mode |=> !illegal); // R9

  AST_FPSTAT_OPEN: assert property (@(posedge clk) disable iff (rst)
    (addr == 16'h0014) |=> !illegal); // R2

  AST_USER_READ_PREV: assert property (@(posedge clk) disable iff (rst)
    (!sup_mode && addr != 16'h0014) |-> rdata == rd_prev); // R3

  AST_TLBX_PASS: assert property (@(posedge clk) disable iff (rst)
    (sup_mode && (addr[15:11] == 5'd1 || addr[15:11] == 5'd2) &&
     addr[10:0] >= 11'd768 && addr[10:0] <= 11'd1535) |-> rdata == rd_prev); // R8

  AST_HALT_SOURCE: assert property (@(posedge clk) disable iff (rst)
    halt |-> $past(wr_en && sup_mode && addr == 16'h4000)); // R7

  AST_HALT_RESUME: assert property (@(posedge clk) disable iff (rst)
    halt |-> resume_pc == $past(pc_in) + PC_W'(4)); // R7

endmodule

bind sreg_access sreg_access_chk #(.DW(DW), .PC_W(PC_W)) u_chk (.*);

// File: tb/test_sreg_access.sv
module test_sreg_access;

  localparam logic [31:0] P_VER   = 32'hCAFE_0102;
  localparam logic [31:0] P_UNITS = 32'h0000_0F15;
  localparam logic [31:0] P_CFG   = 32'h0000_0A20;
  localparam logic [31:0] P_CID   = 32'h0000_0003;
  localparam logic [31:0] P_NCORE = 32'h0000_0008;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] addr = '0;
  logic [31:0] wdata = '0, rd_prev = '0, pc_in = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0, sup_mode = 1'b0;
  logic [31:0] rdata, resume_pc;
  logic        illegal, halt;

  int checks = 0;
  int failures = 0;

  logic [31:0] m_fp, m_vb, m_epc, m_ea, m_es, m_pwr;
  logic [63:0] m_acc;
  logic [31:0] m_sh [128];

  always #5 clk = ~clk;

  sreg_access #(
    .VERSION_VAL(P_VER), .UNITS_VAL(P_UNITS), .CFG_VAL(P_CFG),
    .CORE_ID(P_CID), .CORE_COUNT(P_NCORE)
  ) i_sreg_access (
    .clk(clk), .rst(rst), .addr(addr), .wdata(wdata), .wr_en(wr_en),
    .rd_en(rd_en), .sup_mode(sup_mode), .rd_prev(rd_prev), .pc_in(pc_in),
    .rdata(rdata), .illegal(illegal), .halt(halt), .resume_pc(resume_pc)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit is_user_blocked(input logic [15:0] a, input bit s);
    return !s && a != 16'h0014;
  endfunction

  function automatic string req_of(input logic [15:0] a, input bit s);
    if (is_user_blocked(a, s)) return "R3";
    case (a)
      16'h0014: return "R2";
      16'h000B, 16'h0020, 16'h0030, 16'h0040: return "R4";
      16'h2801, 16'h2802: return "R6";
      16'h4000: return "R7";
      16'h0000, 16'h0001, 16'h0002, 16'h0080, 16'h0081: return "R10";
      default: begin
        if (a >= 16'h0400 && a < 16'h0480) return "R5";
        if ((a[15:11] == 5'd1 || a[15:11] == 5'd2) && a[10:0] >= 11'd768 && a[10:0] <= 11'd1535)
          return "R8";
        return "R9";
      end
    endcase
  endfunction

  function automatic logic [31:0] exp_read(input logic [15:0] a, input bit s, input logic [31:0] prev);
    if (is_user_blocked(a, s)) return prev;
    case (a)
      16'h0014: return m_fp;
      16'h000B: return m_vb;
      16'h0020: return m_epc;
      16'h0030: return m_ea;
      16'h0040: return m_es;
      16'h2801: return m_acc[31:0];
      16'h2802: return m_acc[63:32];
      16'h4000: return m_pwr;
      16'h0000: return P_VER;
      16'h0001: return P_UNITS;
      16'h0002: return P_CFG;
      16'h0080: return P_CID;
      16'h0081: return P_NCORE;
      default: begin
        if (a >= 16'h0400 && a < 16'h0480) return m_sh[a - 16'h0400];
        return prev;
      end
    endcase
  endfunction

  task automatic model_write(input logic [15:0] a, input logic [31:0] d, input bit s);
    if (is_user_blocked(a, s)) return;
    case (a)
      16'h0014: m_fp  = d;
      16'h000B: m_vb  = d;
      16'h0020: m_epc = d;
      16'h0030: m_ea  = d;
      16'h0040: m_es  = d;
      16'h2801: m_acc[31:0]  = d;
      16'h2802: m_acc[63:32] = d;
      16'h4000: m_pwr = d;
      default: if (a >= 16'h0400 && a < 16'h0480) m_sh[a - 16'h0400] = d;
    endcase
  endtask

  // one access: drive on the falling edge, check rdata in that cycle,
  // check the registered pulses just after the next rising edge
  task automatic acc(input bit w, input logic [15:0] a, input logic [31:0] d,
                     input bit s, input logic [31:0] prev, input logic [31:0] pc);
    string       tag;
    bit          exp_ill, exp_halt;
    logic [31:0] exp_rd;
    tag      = req_of(a, s);
    exp_ill  = is_user_blocked(a, s);
    exp_halt = w && s && a == 16'h4000 && (d[4] || d[5]);
    exp_rd   = exp_read(a, s, prev);
    @(negedge clk);
    addr = a; wr_en = w; rd_en = !w; wdata = d; sup_mode = s; rd_prev = prev; pc_in = pc;
    #1;
    if (!w) chk({tag, " rdata"}, rdata, exp_rd);
    @(posedge clk);
    #1;
    chk({tag, " illegal"}, {31'd0, illegal}, {31'd0, exp_ill});
    chk({tag, " halt"}, {31'd0, halt}, {31'd0, exp_halt});
    if (exp_halt) chk("R7 resume_pc", resume_pc, pc + 32'd4);
    if (w) model_write(a, d, s);
  endtask

  task automatic idle_chk(input string req);
    @(negedge clk);
    wr_en = 1'b0; rd_en = 1'b0;
    @(posedge clk);
    #1;
    chk({req, " halt idle"}, {31'd0, halt}, 32'd0);
    chk({req, " illegal idle"}, {31'd0, illegal}, 32'd0);
  endtask

  function automatic logic [15:0] pick_addr();
    case ($urandom % 20)
      0, 19: return 16'h0014;
      1:  return 16'h000B;
      2:  return 16'h0020;
      3:  return 16'h0030;
      4:  return 16'h0040;
      5:  return 16'h0000;
      6:  return 16'h0001;
      7:  return 16'h0002;
      8:  return 16'h0080;
      9:  return 16'h0081;
      10: return 16'h2801;
      11: return 16'h2802;
      12: return 16'h4000;
      13, 14: return 16'(16'h0400 + ($urandom % 128));
      15: return 16'(16'h0B00 + ($urandom % 768));
      16: return 16'(16'h1300 + ($urandom % 768));
      17: return 16'($urandom);
      default: return 16'(16'h0480 + ($urandom % 64));
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    m_fp = '0; m_vb = '0; m_epc = '0; m_ea = '0; m_es = '0; m_pwr = '0; m_acc = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R1 illegal reset", {31'd0, illegal}, 32'd0);
    chk("R1 halt reset", {31'd0, halt}, 32'd0);
    // R1: all writable registers read back as zero
    acc(0, 16'h0014, 0, 1, 32'h1111_1111, 0);
    acc(0, 16'h000B, 0, 1, 32'h1111_1111, 0);
    acc(0, 16'h0020, 0, 1, 32'h1111_1111, 0);
    acc(0, 16'h0030, 0, 1, 32'h1111_1111, 0);
    acc(0, 16'h0040, 0, 1, 32'h1111_1111, 0);
    acc(0, 16'h2801, 0, 1, 32'h1111_1111, 0);
    acc(0, 16'h2802, 0, 1, 32'h1111_1111, 0);
    acc(0, 16'h4000, 0, 1, 32'h1111_1111, 0);

    // R5: fill every shadow entry, then read bank edges
    for (int i = 0; i < 128; i++) acc(1, 16'(16'h0400 + i), $urandom, 1, 0, 0);
    acc(0, 16'h041F, 0, 1, 32'hDEAD_0001, 0);
    acc(0, 16'h0420, 0, 1, 32'hDEAD_0002, 0);
    acc(0, 16'h047F, 0, 1, 32'hDEAD_0003, 0);
    acc(0, 16'h0400, 0, 1, 32'hDEAD_0004, 0);
    acc(0, 16'h0480, 0, 1, 32'hDEAD_0005, 0); // R9 past last bank

    // R2: floating-point status from user mode
    acc(1, 16'h0014, 32'h0000_0C1F, 0, 0, 0);
    acc(0, 16'h0014, 0, 0, 32'h5555_5555, 0);

    // R4 then R3: supervisor write, user write rejected, old value kept
    acc(1, 16'h000B, 32'h0000_2000, 1, 0, 0);
    acc(1, 16'h000B, 32'hBAD0_BAD0, 0, 0, 0);
    acc(0, 16'h000B, 0, 1, 32'h7777_7777, 0);
    acc(0, 16'h000B, 0, 0, 32'h7777_7777, 0);
    acc(1, 16'h0020, 32'h1234_5678, 1, 0, 0);
    acc(1, 16'h0030, 32'h9ABC_DEF0, 1, 0, 0);
    acc(1, 16'h0040, 32'h0000_8001, 1, 0, 0);
    acc(0, 16'h0020, 0, 1, 0, 0);
    acc(0, 16'h0030, 0, 1, 0, 0);
    acc(0, 16'h0040, 0, 1, 0, 0);
    acc(1, 16'h0400, 32'h0BAD_F00D, 0, 0, 0); // R3 shadow untouched
    acc(0, 16'h0400, 0, 1, 0, 0);

    // R6: halves are independent
    acc(1, 16'h2801, 32'hAAAA_0001, 1, 0, 0);
    acc(1, 16'h2802, 32'hBBBB_0002, 1, 0, 0);
    acc(1, 16'h2801, 32'hCCCC_0003, 1, 0, 0);
    acc(0, 16'h2802, 0, 1, 0, 0);
    acc(0, 16'h2801, 0, 1, 0, 0);

    // R7: doze bit, sleep bit, neither
    acc(1, 16'h4000, 32'h0000_0010, 1, 0, 32'h0000_1000);
    idle_chk("R7");
    acc(1, 16'h4000, 32'h0000_0020, 1, 0, 32'hFFFF_FFFC);
    idle_chk("R7");
    acc(1, 16'h4000, 32'h0000_000F, 1, 0, 32'h0000_2000);
    acc(0, 16'h4000, 0, 1, 0, 0);
    acc(1, 16'h4000, 32'h0000_0030, 0, 0, 32'h0000_3000); // R3 user: no halt

    // R8: upper translation-way ranges
    acc(1, 16'h0B00, 32'h1357_9BDF, 1, 0, 0);
    acc(0, 16'h0B00, 0, 1, 32'h2468_ACE0, 0);
    acc(0, 16'h0DFF, 0, 1, 32'h0F0F_0F0F, 0);
    acc(1, 16'h1300, 32'hFFFF_FFFF, 1, 0, 0);
    acc(0, 16'h15FF, 0, 1, 32'h3C3C_3C3C, 0);
    acc(0, 16'h0400, 0, 1, 0, 0);

    // R9: unmapped
    acc(1, 16'h7FFF, 32'h4444_4444, 1, 0, 0);
    acc(0, 16'h7FFF, 0, 1, 32'h8888_8888, 0);

    // R10: constants ignore writes
    acc(1, 16'h0000, 32'hFFFF_FFFF, 1, 0, 0);
    acc(0, 16'h0000, 0, 1, 0, 0);
    acc(1, 16'h0081, 32'h0000_00FF, 1, 0, 0);
    acc(0, 16'h0081, 0, 1, 0, 0);
    acc(0, 16'h0080, 0, 1, 0, 0);
    acc(0, 16'h0001, 0, 1, 0, 0);
    acc(0, 16'h0002, 0, 1, 0, 0);

    // mixed random traffic
    for (int n = 0; n < 600; n++) begin
      acc(1'($urandom % 2), pick_addr(), $urandom, 1'(($urandom % 4) != 0), $urandom, $urandom);
    end
    idle_chk("R7");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule